// File: doc/BRIEF.md
# Status Flag Acknowledge Register

This block holds the eight condition flags of a serial port: six receive-side flags and two transmit-side flags. The receiver and transmitter each report an event with a one-cycle set pulse. Software clears a flag in two steps. First it reads the status register while the flag is set. Then it makes the matching access to the data register: a read clears receive flags, and a write clears transmit flags. The block records which flags were visible at the status read, so only those flags can be cleared by the access that follows.

Flags that are raised after the status read survive the data access. This also holds when a flag that was already set gets a fresh set pulse. Receive flags are held off while the receiver is disabled and while the port sleeps in wakeup mode. Wakeup mode is entered on request and leaves by itself when an awaken event arrives. A single combined access can read both registers back to back. It clears the receive flags that were set at that moment and does not touch the transmit flags.

Top module: `stat_ack_top`

## Requirements
- R1: After reset, `statusOut` is all zeros and `sleepMode` is low.
- R2: A pulse on `rxSetPulse[i]` (with `rxEnable` high and `sleepMode` low) sets `statusOut[i]`, and a pulse on `txSetPulse[j]` sets `statusOut[6+j]`, both visible on the clock after the pulse. Bits 0..5 are receive flags and bits 6..7 are transmit flags.
- R3: While `rxEnable` is low, receive set pulses have no effect. Transmit flags are still set.
- R4: While `sleepMode` is high, receive set pulses have no effect. Transmit flags are still set.
- R5: A `sleepSet` pulse raises `sleepMode`. A `wakeEvent` while `sleepMode` is high lowers it on the next clock, and the wake takes priority over a `sleepSet` in the same cycle.
- R6: A status read (`accSel`=0, `accWrite`=0, either byte lane) taken while a receive flag is set, followed by a data read (`accSel`=1, `accWrite`=0, `accLaneLo`=1), clears that flag.
- R7: A data read never clears a transmit flag. A data write with `accLaneLo`=1 after a status read clears the transmit flags that were seen set at that read, and leaves the receive flags alone.
- R8: A read with `accPair`=1 (status and data read back to back) clears every receive flag set in that cycle and leaves the transmit flags unchanged.
- R9: A flag that is not set at the status read, or that gets a new set pulse after the status read, is not cleared by the following data access. A fresh status read then lets it clear.
- R10: A data access with no status read before it clears nothing. So do an upper-lane-only data access (`accLaneLo`=0) and a status write.
- R11: When a set pulse and a clear for the same flag land in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Register access present this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSel | input | 1 | 0 = status register, 1 = data register |
| accLaneLo | input | 1 | Lower byte lane selected |
| accLaneHi | input | 1 | Upper byte lane selected |
| accPair | input | 1 | Read covers status then data register back to back |
| rxEnable | input | 1 | Receiver enabled |
| sleepSet | input | 1 | Request to enter wakeup mode |
| wakeEvent | input | 1 | Idle-line or address-mark awaken event |
| rxSetPulse | input | 6 | Receive flag set pulses |
| txSetPulse | input | 2 | Transmit flag set pulses |
| statusOut | output | 8 | Current flag register |
| sleepMode | output | 1 | Wakeup mode active |

## Verification
The bench targets the race windows. In one case a flag is raised between the status read and the data access. In another, an already-set flag gets a new pulse in that window. A design that only tests the current flag value would wrongly clear both. The bench also checks the transmit flags against a data read and a combined read; a design that treats all flags the same would drop them. It checks upper-lane-only data accesses, status writes and data accesses with no status read before them, where a loose decoder would clear flags it should leave. Last, it sets a flag and clears it in the same cycle, where a design with the priority inverted would lose the event.

// File: rtl/stat_ack_pkg.sv
package stat_ack_pkg;
  // Strobes passed from the access decoder to the flag datapath
  typedef struct packed {
    logic snapLoad;  // capture currently visible flags
    logic rxClr;     // clear captured receive flags
    logic txClr;     // clear captured transmit flags
    logic rxGate;    // receive set pulses allowed
  } ackStrobe_t;
endpackage

// File: rtl/stat_ack_ctrl.sv
module stat_ack_ctrl
  import stat_ack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accValid,
  input  logic       accWrite,
  input  logic       accSel,
  input  logic       accLaneLo,
  input  logic       accLaneHi,
  input  logic       accPair,
  input  logic       rxEnable,
  input  logic       sleepSet,
  input  logic       wakeEvent,
  output ackStrobe_t strobes,
  output logic       sleepMode
);
  logic rdAcc, wrAcc, pairRd, statusRd, dataRd, dataWr;

  always_comb begin
    rdAcc    = accValid && !accWrite;
    wrAcc    = accValid && accWrite;
    pairRd   = rdAcc && accPair;
    statusRd = rdAcc && !accPair && !accSel && (accLaneLo || accLaneHi);
    dataRd   = rdAcc && !accPair && accSel && accLaneLo;
    dataWr   = wrAcc && accSel && accLaneLo;

    strobes.snapLoad = statusRd || pairRd;
    strobes.rxClr    = dataRd || pairRd;
    strobes.txClr    = dataWr;
    strobes.rxGate   = rxEnable && !sleepMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       sleepMode <= 1'b0;
    else if (sleepMode && wakeEvent) sleepMode <= 1'b0;
    else if (sleepSet)               sleepMode <= 1'b1;
  end
endmodule

// File: rtl/stat_ack_dp.sv
module stat_ack_dp
  import stat_ack_pkg::*;
#(
  parameter int RX_FLAGS = 6,
  parameter int TX_FLAGS = 2,
  localparam int NFLAGS  = RX_FLAGS + TX_FLAGS
) (
  input  logic                clk,
  input  logic                rstN,
  input  ackStrobe_t          strobes,
  input  logic [RX_FLAGS-1:0] rxSetPulse,
  input  logic [TX_FLAGS-1:0] txSetPulse,
  output logic [NFLAGS-1:0]   flags
);
  logic [NFLAGS-1:0] snap;
  logic [NFLAGS-1:0] setEff, snapBase, clrHit, flagNext, snapNext;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_bit
    if (i < RX_FLAGS) begin : g_rx
      always_comb begin
        setEff[i] = rxSetPulse[i] && strobes.rxGate;
        clrHit[i] = snapBase[i] && strobes.rxClr;
      end
    end else begin : g_tx
      always_comb begin
        setEff[i] = txSetPulse[i-RX_FLAGS];
        clrHit[i] = snapBase[i] && strobes.txClr;
      end
    end
    always_comb begin
      snapBase[i] = strobes.snapLoad ? flags[i] : snap[i];
      // a set event always beats a clear in the same cycle
      flagNext[i] = setEff[i] || (flags[i] && !clrHit[i]);
      // a capture is consumed by its clear and voided by a later set
      snapNext[i] = snapBase[i] && !clrHit[i] && !setEff[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= '0;
      snap  <= '0;
    end else begin
      flags <= flagNext;
      snap  <= snapNext;
    end
  end
endmodule

// File: rtl/stat_ack_top.sv
module stat_ack_top
  import stat_ack_pkg::*;
#(
  parameter int RX_FLAGS = 6,
  parameter int TX_FLAGS = 2,
  localparam int NFLAGS  = RX_FLAGS + TX_FLAGS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accValid,
  input  logic                accWrite,
  input  logic                accSel,
  input  logic                accLaneLo,
  input  logic                accLaneHi,
  input  logic                accPair,
  input  logic                rxEnable,
  input  logic                sleepSet,
  input  logic                wakeEvent,
  input  logic [RX_FLAGS-1:0] rxSetPulse,
  input  logic [TX_FLAGS-1:0] txSetPulse,
  output logic [NFLAGS-1:0]   statusOut,
  output logic                sleepMode
);
  ackStrobe_t strobes;

  stat_ack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSel(accSel), .accLaneLo(accLaneLo), .accLaneHi(accLaneHi),
    .accPair(accPair), .rxEnable(rxEnable), .sleepSet(sleepSet),
    .wakeEvent(wakeEvent), .strobes(strobes), .sleepMode(sleepMode)
  );

  stat_ack_dp #(.RX_FLAGS(RX_FLAGS), .TX_FLAGS(TX_FLAGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxSetPulse(rxSetPulse),
    .txSetPulse(txSetPulse), .flags(statusOut)
  );
endmodule

// File: rtl/stat_ack_chk.sv
module stat_ack_chk #(
  parameter int RX_FLAGS = 6,
  parameter int TX_FLAGS = 2,
  localparam int NFLAGS  = RX_FLAGS + TX_FLAGS
) (
  input logic                clk,
  input logic                rstN,
  input logic                accValid,
  input logic                accWrite,
  input logic                accSel,
  input logic                accLaneLo,
  input logic                accPair,
  input logic                rxEnable,
  input logic                wakeEvent,
  input logic [RX_FLAGS-1:0] rxSetPulse,
  input logic [NFLAGS-1:0]   statusOut,
  input logic                sleepMode
);
  localparam logic [NFLAGS-1:0] RX_MASK = {{TX_FLAGS{1'b0}}, {RX_FLAGS{1'b1}}};
  localparam logic [NFLAGS-1:0] TX_MASK = ~RX_MASK;

  logic clearingAcc;
  always_comb
    clearingAcc = accValid && ((!accWrite && (accPair || (accSel && accLaneLo)))
                               || (accWrite && accSel && accLaneLo));

  // R2
  rx_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxSetPulse[0] && rxEnable && !sleepMode) |=> statusOut[0]);

  // R3
  rx_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> ((statusOut & ~$past(statusOut) & RX_MASK) == '0));

  // R4
  sleep_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepMode |=> ((statusOut & ~$past(statusOut) & RX_MASK) == '0));

  // R5
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode && wakeEvent) |=> !sleepMode);

  // R7
  tx_read_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite) |=> (($past(statusOut) & ~statusOut & TX_MASK) == '0));

  // R10
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clearingAcc |=> (($past(statusOut) & ~statusOut) == '0));
endmodule

bind stat_ack_top stat_ack_chk #(.RX_FLAGS(RX_FLAGS), .TX_FLAGS(TX_FLAGS)) u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
  .accSel(accSel), .accLaneLo(accLaneLo), .accPair(accPair),
  .rxEnable(rxEnable), .wakeEvent(wakeEvent), .rxSetPulse(rxSetPulse),
  .statusOut(statusOut), .sleepMode(sleepMode)
);

// File: tb/sim_stat_ack_top.sv
module sim_stat_ack_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 0, accWrite = 0, accSel = 0, accLaneLo = 0, accLaneHi = 0, accPair = 0;
  logic rxEnable = 1, sleepSet = 0, wakeEvent = 0;
  logic [5:0] rxSetPulse = '0;
  logic [1:0] txSetPulse = '0;
  logic [7:0] statusOut;
  logic       sleepMode;
  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  stat_ack_top u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleIn();
    accValid = 0; accWrite = 0; accSel = 0; accLaneLo = 0; accLaneHi = 0; accPair = 0;
    sleepSet = 0; wakeEvent = 0; rxSetPulse = '0; txSetPulse = '0;
  endtask

  task automatic doReset();
    @(negedge clk); idleIn(); rxEnable = 1; rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  // one cycle of stimulus, results visible at the next falling edge
  task automatic step(input logic [5:0] rx, input logic [1:0] tx);
    rxSetPulse = rx; txSetPulse = tx;
    @(negedge clk); idleIn();
  endtask

  task automatic acc(input logic wr, input logic sel, input logic lo, input logic hi,
                     input logic pr, input logic [5:0] rx, input logic [1:0] tx);
    accValid = 1; accWrite = wr; accSel = sel; accLaneLo = lo; accLaneHi = hi; accPair = pr;
    step(rx, tx);
  endtask

  task automatic t_reset();
    doReset();
    check("R1 flags", statusOut, 8'h00);
    check("R1 sleep", {7'd0, sleepMode}, 8'h00);
  endtask

  task automatic t_set();
    doReset();
    step(6'b101101, 2'b00);
    check("R2 rx set", statusOut, 8'h2D);
    step(6'b000000, 2'b11);
    check("R2 tx set", statusOut, 8'hED);
  endtask

  task automatic t_rxOff();
    doReset();
    rxEnable = 0;
    step(6'h3F, 2'b00);
    check("R3 rx blocked", statusOut, 8'h00);
    step(6'h00, 2'b10);
    check("R3 tx still set", statusOut, 8'h80);
    rxEnable = 1;
  endtask

  task automatic t_sleep();
    doReset();
    sleepSet = 1; step(6'h00, 2'b00);
    check("R5 sleep entered", {7'd0, sleepMode}, 8'h01);
    step(6'h3F, 2'b01);
    check("R4 rx blocked tx set", statusOut, 8'h40);
    sleepSet = 1; wakeEvent = 1; step(6'h00, 2'b00);
    check("R5 wake wins", {7'd0, sleepMode}, 8'h00);
    step(6'h01, 2'b00);
    check("R4 rx after wake", statusOut, 8'h41);
  endtask

  task automatic t_rxClear();
    doReset();
    step(6'b000101, 2'b01);
    acc(0, 0, 0, 1, 0, 6'h00, 2'b00);   // status read, upper lane only
    check("R6 status read no clear", statusOut, 8'h45);
    acc(0, 1, 1, 0, 0, 6'h00, 2'b00);   // data read, lower lane
    check("R6 rx cleared tx kept", statusOut, 8'h40);
  endtask

  task automatic t_txClear();
    doReset();
    step(6'b000010, 2'b11);
    acc(0, 0, 1, 0, 0, 6'h00, 2'b00);
    acc(1, 1, 1, 0, 0, 6'h00, 2'b00);   // data write
    check("R7 tx cleared rx kept", statusOut, 8'h02);
  endtask

  task automatic t_pair();
    doReset();
    step(6'h3F, 2'b01);
    acc(0, 0, 1, 1, 1, 6'h00, 2'b00);
    check("R8 pair read", statusOut, 8'h40);
  endtask

  task automatic t_race();
    doReset();
    step(6'b000001, 2'b00);
    acc(0, 0, 1, 0, 0, 6'h00, 2'b00);
    step(6'b000011, 2'b00);             // new flag and a re-set of a seen flag
    acc(0, 1, 1, 0, 0, 6'h00, 2'b00);
    check("R9 late flags survive", statusOut, 8'h03);
    acc(0, 0, 1, 0, 0, 6'h00, 2'b00);
    acc(0, 1, 1, 0, 0, 6'h00, 2'b00);
    check("R9 fresh read clears", statusOut, 8'h00);
  endtask

  task automatic t_noStatus();
    doReset();
    step(6'b000001, 2'b01);
    acc(0, 1, 1, 0, 0, 6'h00, 2'b00);
    check("R10 data read without status", statusOut, 8'h41);
    acc(1, 1, 1, 0, 0, 6'h00, 2'b00);
    check("R10 data write without status", statusOut, 8'h41);
    acc(1, 0, 1, 1, 0, 6'h00, 2'b00);   // status write
    acc(0, 1, 1, 0, 0, 6'h00, 2'b00);
    check("R10 status write no capture", statusOut, 8'h41);
    acc(0, 0, 1, 0, 0, 6'h00, 2'b00);
    acc(0, 1, 0, 1, 0, 6'h00, 2'b00);   // upper-lane data read
    acc(1, 1, 0, 1, 0, 6'h00, 2'b00);   // upper-lane data write
    check("R10 upper lane ignored", statusOut, 8'h41);
    acc(0, 1, 1, 1, 0, 6'h00, 2'b00);
    check("R10 capture kept for full read", statusOut, 8'h40);
  endtask

  task automatic t_setWins();
    doReset();
    step(6'b000001, 2'b01);
    acc(0, 0, 1, 0, 0, 6'h00, 2'b00);
    acc(0, 1, 1, 0, 0, 6'b000001, 2'b00);
    check("R11 rx set beats clear", statusOut, 8'h41);
    acc(1, 1, 1, 0, 0, 6'h00, 2'b01);
    check("R11 tx set beats clear", statusOut, 8'h41);
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_set();
    t_rxOff();
    t_sleep();
    t_rxClear();
    t_txClear();
    t_pair();
    t_race();
    t_noStatus();
    t_setWins();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule